// File: doc/BRIEF.md
# SD/MMC Host Status Flag Register

This block gathers the event pulses of an SD/MMC host controller into one read-only status word. The command path, read-data path, write-data path, data FIFO and boot logic raise single-cycle event pulses. Each pulse sets a sticky flag, and the flag stays set until firmware starts a new operation of the class it belongs to. Firmware starts an operation with a send-command, read-data or write-data launch strobe. A boot-acknowledge flag works differently: it clears when the expect-boot-acknowledge mode bit falls.

The same word also carries live copies of the card-detect input, the DAT0 and DAT3 pin levels, the DLL lock level and its inverse. It also holds the result of the most recent SDIO interrupt sample. Firmware reads the 19 defined bits through a single-cycle registered read port. Bits above bit 18 read as zero.

Top module: `sdmmc_status_reg`

## Requirements
- R1: On synchronous active-high reset, every sticky flag, the held SDIO sample and the read data output are 0.
- R2: Bits 0 (command sent), 1 (response received), 2 (response timeout), 3 (CRC7 error) and 13 (command-completion signal) set on their event pulse. They stay set until a cycle with the send-command launch strobe high, which clears all five.
- R3: Bits 5 (read blocks all received), 6 (read data timeout), 11 (FIFO overflow during read) and 18 (read-end data error) are sticky and clear on the read-data launch strobe.
- R4: Bits 4 (write blocks all complete) and 12 (FIFO underflow during write) are sticky and clear on the write-data launch strobe.
- R5: Bit 7 sets on a data CRC failure in either the read or the write direction. It clears on either the read-data or the write-data launch strobe.
- R6: Bit 14 sets on a boot-acknowledge event. No launch strobe clears it. It clears only in the cycle where the expect-boot-acknowledge mode input goes from 1 to 0.
- R7: Bit 18 sets only when the last-read-byte pulse arrives while clock-stop-at-read-end is enabled and a command, response or NRC count is busy. If either of the other two conditions is missing, the pulse has no effect.
- R8: Bits 9, 10 and 17 are live, non-sticky copies of card-detect (1 means a card is inserted), the DAT3 pin and the DAT0 pin.
- R9: Bit 16 equals the DLL lock input, and bit 15 is always its inverse.
- R10: Bit 8 holds the value of the most recent SDIO interrupt sample. It is updated only in cycles with the sample-valid input high.
- R11: When a set event and a clearing strobe for the same bit arrive in the same cycle, the bit ends up set.
- R12: A read of the status address returns the word one clock later, with bits above 18 equal to 0. A read of any other address returns 0.
- R13: A launch strobe leaves every flag outside its own class unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_launch | input | 1 | Send-command launch strobe |
| rd_launch | input | 1 | Read-data launch strobe |
| wr_launch | input | 1 | Write-data launch strobe |
| boot_ack_en | input | 1 | Expect-boot-acknowledge mode level |
| ev_cmd_sent | input | 1 | Command transmitted pulse |
| ev_resp_rcvd | input | 1 | Response received pulse |
| ev_resp_timeout | input | 1 | Response timeout pulse |
| ev_crc7_err | input | 1 | Response CRC error pulse |
| ev_cmd_done_sig | input | 1 | Command-completion signal pulse |
| ev_rd_blocks_done | input | 1 | All read blocks received pulse |
| ev_rd_timeout | input | 1 | Read data timeout pulse |
| ev_fifo_overflow | input | 1 | FIFO overflow during read pulse |
| ev_wr_blocks_done | input | 1 | All write blocks complete pulse |
| ev_fifo_underflow | input | 1 | FIFO underflow during write pulse |
| ev_crc16_rd | input | 1 | Data CRC failure on read pulse |
| ev_crc16_wr | input | 1 | Data CRC failure on write pulse |
| ev_boot_ack | input | 1 | Boot acknowledge detected pulse |
| rd_last_byte | input | 1 | Last byte of last read block taken |
| rd_clk_stop_en | input | 1 | Clock-stop-at-read-end enabled |
| cmd_busy | input | 1 | Command, response or NRC count in progress |
| sdio_smp_valid | input | 1 | SDIO interrupt sample strobe |
| sdio_smp_val | input | 1 | SDIO interrupt sample value |
| card_present | input | 1 | Card-detect level |
| dat3_pin | input | 1 | DAT3 pin level |
| dat0_pin | input | 1 | DAT0 pin level |
| dll_locked | input | 1 | DLL lock level |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register read address |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
The bench targets cross-class clearing. Write-data and send-command launches are issued while read flags are set, and each flag class must survive the other classes' strobes. A design with a wrong clear mask would silently drop an error firmware has not yet seen. The shared data CRC bit is set from both directions and cleared from both strobes, so a design that tied it to a single class fails either the set or the clear. The read-end error is driven with each enabling condition missing in turn; a design that decodes it from fewer conditions raises a false error. The bench also covers a set event that lands in the same cycle as its clearing strobe, where a clear-priority design would lose the event. Finally, it checks that the boot flag survives every launch strobe and clears only on the falling mode bit.

// File: rtl/sdst_pkg.sv
package sdst_pkg;
  localparam int STAT_W = 19;

  localparam int B_CMD_SENT   = 0;
  localparam int B_RESP_RCVD  = 1;
  localparam int B_RESP_TO    = 2;
  localparam int B_CRC7       = 3;
  localparam int B_WR_DONE    = 4;
  localparam int B_RD_DONE    = 5;
  localparam int B_RD_TO      = 6;
  localparam int B_CRC16      = 7;
  localparam int B_SDIO_INT   = 8;
  localparam int B_CARD       = 9;
  localparam int B_DAT3       = 10;
  localparam int B_FIFO_OVF   = 11;
  localparam int B_FIFO_UNF   = 12;
  localparam int B_CMD_DONE   = 13;
  localparam int B_BOOT_ACK   = 14;
  localparam int B_UNLOCKED   = 15;
  localparam int B_LOCKED     = 16;
  localparam int B_DAT0       = 17;
  localparam int B_RD_END_ERR = 18;

  localparam logic [STAT_W-1:0] ONE = STAT_W'(1);

  localparam logic [STAT_W-1:0] CMD_CLR =
    (ONE << B_CMD_SENT) | (ONE << B_RESP_RCVD) | (ONE << B_RESP_TO) |
    (ONE << B_CRC7) | (ONE << B_CMD_DONE);
  localparam logic [STAT_W-1:0] RD_CLR =
    (ONE << B_RD_DONE) | (ONE << B_RD_TO) | (ONE << B_FIFO_OVF) |
    (ONE << B_RD_END_ERR) | (ONE << B_CRC16);
  localparam logic [STAT_W-1:0] WR_CLR =
    (ONE << B_WR_DONE) | (ONE << B_FIFO_UNF) | (ONE << B_CRC16);
  localparam logic [STAT_W-1:0] BOOT_CLR = (ONE << B_BOOT_ACK);

  localparam logic [STAT_W-1:0] STICKY_MASK = CMD_CLR | RD_CLR | WR_CLR | BOOT_CLR;
endpackage

// File: rtl/stat_event_map.sv
module stat_event_map
  import sdst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_launch,
  input  logic              rd_launch,
  input  logic              wr_launch,
  input  logic              boot_ack_en,
  input  logic              ev_cmd_sent,
  input  logic              ev_resp_rcvd,
  input  logic              ev_resp_timeout,
  input  logic              ev_crc7_err,
  input  logic              ev_cmd_done_sig,
  input  logic              ev_rd_blocks_done,
  input  logic              ev_rd_timeout,
  input  logic              ev_fifo_overflow,
  input  logic              ev_wr_blocks_done,
  input  logic              ev_fifo_underflow,
  input  logic              ev_crc16_rd,
  input  logic              ev_crc16_wr,
  input  logic              ev_boot_ack,
  input  logic              rd_last_byte,
  input  logic              rd_clk_stop_en,
  input  logic              cmd_busy,
  output logic [STAT_W-1:0] set_vec,
  output logic [STAT_W-1:0] clr_vec
);
  logic boot_en_q;
  logic boot_fall;
  logic rd_end_err;

  // Mode bit history for the boot flag clear (falling edge only)
  always_ff @(posedge clk) begin
    if (rst) boot_en_q <= 1'b0;
    else     boot_en_q <= boot_ack_en;
  end

  assign boot_fall  = boot_en_q & ~boot_ack_en;
  assign rd_end_err = rd_last_byte & rd_clk_stop_en & cmd_busy;

  always_comb begin
    set_vec               = '0;
    set_vec[B_CMD_SENT]   = ev_cmd_sent;
    set_vec[B_RESP_RCVD]  = ev_resp_rcvd;
    set_vec[B_RESP_TO]    = ev_resp_timeout;
    set_vec[B_CRC7]       = ev_crc7_err;
    set_vec[B_CMD_DONE]   = ev_cmd_done_sig;
    set_vec[B_RD_DONE]    = ev_rd_blocks_done;
    set_vec[B_RD_TO]      = ev_rd_timeout;
    set_vec[B_FIFO_OVF]   = ev_fifo_overflow;
    set_vec[B_WR_DONE]    = ev_wr_blocks_done;
    set_vec[B_FIFO_UNF]   = ev_fifo_underflow;
    set_vec[B_CRC16]      = ev_crc16_rd | ev_crc16_wr;
    set_vec[B_BOOT_ACK]   = ev_boot_ack;
    set_vec[B_RD_END_ERR] = rd_end_err;
  end

  assign clr_vec = ({STAT_W{cmd_launch}} & CMD_CLR) |
                   ({STAT_W{rd_launch}}  & RD_CLR)  |
                   ({STAT_W{wr_launch}}  & WR_CLR)  |
                   ({STAT_W{boot_fall}}  & BOOT_CLR);
endmodule

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank #(
  parameter int          WIDTH = 19,
  parameter logic [WIDTH-1:0] STICKY = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] flags
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (STICKY[i]) begin : g_flag
      logic q;
      // Set has priority over clear in the same cycle
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set_vec[i] | (q & ~clr_vec[i]);
      end
      assign flags[i] = q;
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port
  import sdst_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] flags,
  input  logic              sdio_smp_valid,
  input  logic              sdio_smp_val,
  input  logic              card_present,
  input  logic              dat3_pin,
  input  logic              dat0_pin,
  input  logic              dll_locked,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic              sdio_q;
  logic [STAT_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst)                 sdio_q <= 1'b0;
    else if (sdio_smp_valid) sdio_q <= sdio_smp_val;
  end

  always_comb begin
    word               = flags;
    word[B_SDIO_INT]   = sdio_q;
    word[B_CARD]       = card_present;
    word[B_DAT3]       = dat3_pin;
    word[B_UNLOCKED]   = ~dll_locked;
    word[B_LOCKED]     = dll_locked;
    word[B_DAT0]       = dat0_pin;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd_en)
      reg_rdata <= (reg_addr == STATUS_ADDR) ? DATA_W'(word) : '0;
  end
endmodule

// File: rtl/sdmmc_status_reg.sv
module sdmmc_status_reg
  import sdst_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_launch,
  input  logic              rd_launch,
  input  logic              wr_launch,
  input  logic              boot_ack_en,
  input  logic              ev_cmd_sent,
  input  logic              ev_resp_rcvd,
  input  logic              ev_resp_timeout,
  input  logic              ev_crc7_err,
  input  logic              ev_cmd_done_sig,
  input  logic              ev_rd_blocks_done,
  input  logic              ev_rd_timeout,
  input  logic              ev_fifo_overflow,
  input  logic              ev_wr_blocks_done,
  input  logic              ev_fifo_underflow,
  input  logic              ev_crc16_rd,
  input  logic              ev_crc16_wr,
  input  logic              ev_boot_ack,
  input  logic              rd_last_byte,
  input  logic              rd_clk_stop_en,
  input  logic              cmd_busy,
  input  logic              sdio_smp_valid,
  input  logic              sdio_smp_val,
  input  logic              card_present,
  input  logic              dat3_pin,
  input  logic              dat0_pin,
  input  logic              dll_locked,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] flags_q;

  stat_event_map u_map (
    .clk(clk), .rst(rst),
    .cmd_launch(cmd_launch), .rd_launch(rd_launch), .wr_launch(wr_launch),
    .boot_ack_en(boot_ack_en),
    .ev_cmd_sent(ev_cmd_sent), .ev_resp_rcvd(ev_resp_rcvd),
    .ev_resp_timeout(ev_resp_timeout), .ev_crc7_err(ev_crc7_err),
    .ev_cmd_done_sig(ev_cmd_done_sig), .ev_rd_blocks_done(ev_rd_blocks_done),
    .ev_rd_timeout(ev_rd_timeout), .ev_fifo_overflow(ev_fifo_overflow),
    .ev_wr_blocks_done(ev_wr_blocks_done), .ev_fifo_underflow(ev_fifo_underflow),
    .ev_crc16_rd(ev_crc16_rd), .ev_crc16_wr(ev_crc16_wr),
    .ev_boot_ack(ev_boot_ack), .rd_last_byte(rd_last_byte),
    .rd_clk_stop_en(rd_clk_stop_en), .cmd_busy(cmd_busy),
    .set_vec(set_vec), .clr_vec(clr_vec)
  );

  stat_sticky_bank #(.WIDTH(STAT_W), .STICKY(STICKY_MASK)) u_bank (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags_q)
  );

  stat_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_port (
    .clk(clk), .rst(rst), .flags(flags_q),
    .sdio_smp_valid(sdio_smp_valid), .sdio_smp_val(sdio_smp_val),
    .card_present(card_present), .dat3_pin(dat3_pin), .dat0_pin(dat0_pin),
    .dll_locked(dll_locked), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/stat_status_checker.sv
module stat_status_checker #(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_launch,
  input logic              rd_launch,
  input logic              wr_launch,
  input logic              boot_ack_en,
  input logic              ev_cmd_sent,
  input logic              ev_rd_timeout,
  input logic              ev_fifo_underflow,
  input logic              ev_boot_ack,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [18:0]       flags_q
);
  logic rd_hit;
  assign rd_hit = reg_rd_en && (reg_addr == STATUS_ADDR);

  a_r2_cmd_sent_sets: assert property (@(posedge clk) disable iff (rst)
    ev_cmd_sent |=> flags_q[0]);

  a_r2_cmd_sent_clears: assert property (@(posedge clk) disable iff (rst)
    cmd_launch && !ev_cmd_sent |=> !flags_q[0]);

  a_r3_rd_timeout_clears: assert property (@(posedge clk) disable iff (rst)
    rd_launch && !ev_rd_timeout |=> !flags_q[6]);

  a_r6_boot_holds: assert property (@(posedge clk) disable iff (rst)
    flags_q[14] && boot_ack_en |=> flags_q[14]);

  a_r6_boot_sets: assert property (@(posedge clk) disable iff (rst)
    ev_boot_ack |=> flags_q[14]);

  a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    ev_fifo_underflow && wr_launch |=> flags_q[12]);

  a_r9_lock_pair: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> reg_rdata[15] != reg_rdata[16]);

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (reg_rdata >> 19) == '0);

  a_r12_miss_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en && !rd_hit |=> reg_rdata == '0);
endmodule

bind sdmmc_status_reg stat_status_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cmd_launch(cmd_launch), .rd_launch(rd_launch),
  .wr_launch(wr_launch), .boot_ack_en(boot_ack_en), .ev_cmd_sent(ev_cmd_sent),
  .ev_rd_timeout(ev_rd_timeout), .ev_fifo_underflow(ev_fifo_underflow),
  .ev_boot_ack(ev_boot_ack), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .flags_q(flags_q)
);

// File: tb/tb_sdmmc_status_reg.sv
`timescale 1ns/1ps
module tb_sdmmc_status_reg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] SADDR = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_launch = 0, rd_launch = 0, wr_launch = 0, boot_ack_en = 0;
  logic ev_cmd_sent = 0, ev_resp_rcvd = 0, ev_resp_timeout = 0, ev_crc7_err = 0;
  logic ev_cmd_done_sig = 0, ev_rd_blocks_done = 0, ev_rd_timeout = 0;
  logic ev_fifo_overflow = 0, ev_wr_blocks_done = 0, ev_fifo_underflow = 0;
  logic ev_crc16_rd = 0, ev_crc16_wr = 0, ev_boot_ack = 0;
  logic rd_last_byte = 0, rd_clk_stop_en = 0, cmd_busy = 0;
  logic sdio_smp_valid = 0, sdio_smp_val = 0;
  logic card_present = 0, dat3_pin = 0, dat0_pin = 0, dll_locked = 0;
  logic reg_rd_en = 0;
  logic [ADDR_W-1:0] reg_addr = SADDR;
  logic [DATA_W-1:0] reg_rdata;

  always #4 clk = ~clk;

  sdmmc_status_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(SADDR)) dut (.*);

  int n_checks = 0;
  int n_fail   = 0;

  // Bench model, built from the requirements
  logic [18:0] m_sticky = '0;
  logic        m_sdio   = 1'b0;
  logic        m_boot_prev = 1'b0;

  localparam logic [18:0] M_CMD  = 19'h0200F; // bits 0-3, 13
  localparam logic [18:0] M_RD   = 19'h408E0; // bits 5,6,7,11,18
  localparam logic [18:0] M_WR   = 19'h01090; // bits 4,7,12

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              rd_seen = 1'b0;

  function automatic logic [DATA_W-1:0] model_word();
    logic [DATA_W-1:0] w;
    w = DATA_W'(m_sticky);
    w[8]  = m_sdio;
    w[9]  = card_present;
    w[10] = dat3_pin;
    w[15] = ~dll_locked;
    w[16] = dll_locked;
    w[17] = dat0_pin;
    return w;
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare read data one cycle after each read
  always @(posedge clk) rd_seen <= reg_rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard: unexpected read data %h expected none", reg_rdata);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  // Driver: issue a read, push the expected word
  task automatic do_read(input string tag, input logic [ADDR_W-1:0] a = SADDR);
    @(negedge clk);
    reg_addr  = a;
    reg_rd_en = 1'b1;
    exp_q.push_back((a == SADDR) ? model_word() : '0);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    {ev_cmd_sent, ev_resp_rcvd, ev_resp_timeout, ev_crc7_err, ev_cmd_done_sig} = '0;
    {ev_rd_blocks_done, ev_rd_timeout, ev_fifo_overflow} = '0;
    {ev_wr_blocks_done, ev_fifo_underflow, ev_crc16_rd, ev_crc16_wr, ev_boot_ack} = '0;
    {rd_last_byte, rd_clk_stop_en, cmd_busy} = '0;
    {cmd_launch, rd_launch, wr_launch} = '0;
  endtask

  // One cycle of events (m uses status bit positions) and launch strobes
  task automatic fire(input logic [18:0] m, input logic crcw, input logic c, input logic r, input logic w);
    logic [18:0] clr, set;
    @(negedge clk);
    ev_cmd_sent = m[0]; ev_resp_rcvd = m[1]; ev_resp_timeout = m[2]; ev_crc7_err = m[3];
    ev_wr_blocks_done = m[4]; ev_rd_blocks_done = m[5]; ev_rd_timeout = m[6];
    ev_crc16_rd = m[7]; ev_crc16_wr = crcw; ev_fifo_overflow = m[11];
    ev_fifo_underflow = m[12]; ev_cmd_done_sig = m[13]; ev_boot_ack = m[14];
    rd_last_byte = m[18]; rd_clk_stop_en = m[18]; cmd_busy = m[18];
    cmd_launch = c; rd_launch = r; wr_launch = w;
    set = m & 19'h478FF;
    if (crcw) set[7] = 1'b1;
    clr = (c ? M_CMD : '0) | (r ? M_RD : '0) | (w ? M_WR : '0);
    m_sticky = set | (m_sticky & ~clr);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic end_case(input logic stop, input logic busy);
    @(negedge clk);
    rd_last_byte = 1'b1; rd_clk_stop_en = stop; cmd_busy = busy;
    if (stop && busy) m_sticky[18] = 1'b1;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic set_boot_en(input logic v);
    @(negedge clk);
    boot_ack_en = v;
    if (m_boot_prev && !v) m_sticky[14] = 1'b0;
    m_boot_prev = v;
    @(negedge clk);
  endtask

  task automatic sdio_sample(input logic valid, input logic v);
    @(negedge clk);
    sdio_smp_valid = valid; sdio_smp_val = v;
    if (valid) m_sdio = v;
    @(negedge clk);
    sdio_smp_valid = 1'b0; sdio_smp_val = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rdata", reg_rdata, '0);
    rst = 1'b0;
    do_read("R1 flags after reset");

    // R2: command class
    fire(19'h0200F, 0, 0, 0, 0);
    do_read("R2 command flags set");
    // R3/R5: read class plus read-direction CRC
    fire(19'h008E0, 0, 0, 0, 0);
    do_read("R3 read flags set");
    // R4: write class
    fire(19'h01010, 0, 0, 0, 0);
    do_read("R4 write flags set");
    // R4/R5/R13: write launch clears 4,12,7 only
    fire('0, 0, 0, 0, 1);
    do_read("R4 R5 R13 write launch clear");
    // R5: write-direction CRC, cleared by read launch
    fire('0, 1, 0, 0, 0);
    do_read("R5 write CRC sets bit 7");
    fire('0, 0, 0, 1, 0);
    do_read("R3 R5 R13 read launch clear");
    fire('0, 0, 1, 0, 0);
    do_read("R2 command launch clear");

    // R7: read-end error conditions
    end_case(1, 0);
    do_read("R7 no busy no error");
    end_case(0, 1);
    do_read("R7 no clock stop no error");
    end_case(1, 1);
    do_read("R7 all conditions set bit 18");
    fire('0, 0, 0, 1, 0);
    do_read("R3 read launch clears bit 18");

    // R11: set and clear in the same cycle
    fire(19'h01000, 0, 0, 0, 1);
    do_read("R11 underflow survives write launch");
    fire(19'h00001, 0, 1, 0, 0);
    do_read("R11 command sent survives command launch");
    fire('0, 0, 1, 0, 1);

    // R6: boot acknowledge
    set_boot_en(1);
    fire(19'h04000, 0, 0, 0, 0);
    do_read("R6 boot ack set");
    fire('0, 0, 1, 1, 1);
    do_read("R6 boot ack survives all launches");
    set_boot_en(0);
    do_read("R6 boot ack cleared on mode fall");

    // R8/R9: live levels
    @(negedge clk); card_present = 1; dat3_pin = 1;
    do_read("R8 card and DAT3 live");
    @(negedge clk); card_present = 0; dat0_pin = 1; dll_locked = 1;
    do_read("R8 R9 DAT0 and lock live");
    @(negedge clk); dat3_pin = 0; dat0_pin = 0; dll_locked = 0;
    do_read("R9 lock lost");

    // R10: SDIO sample
    sdio_sample(1, 1);
    do_read("R10 sample high");
    sdio_sample(0, 0);
    do_read("R10 no strobe holds");
    sdio_sample(1, 0);
    do_read("R10 sample low");

    // R12: other address and upper bits
    fire(19'h478FF, 0, 0, 0, 0);
    do_read("R12 all flags upper zero");
    do_read("R12 other address zero", 8'h40);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule